// File: doc/BRIEF.md
# Banked CMOS Real-Time-Clock Register File

This block is the battery-style configuration and clock memory of a PC-compatible system. A processor reaches it through two byte ports. A write to the index port selects a register and also sets a flag that masks the non-maskable interrupt. Accesses to the data port then read or write the selected register. The store holds 64 bytes in its base build. When `EXTENDED` is set at elaboration it holds 192 bytes. In that build the index is 7 bits wide, and a bank bit taken from an outside chipset register moves indices 64 to 127 onto a third 64-byte page.

Three registers apply write masks: status A (divider and rate), status B (mode) and status D (power valid). Seconds, minutes and hours come from a free-running time base that a parameter scales. They read back as packed BCD or as binary, as status B selects. Status A shows an update-in-progress flag for one clock in every second. A host-side port gives raw byte access to the whole array, so the contents can be preloaded at start-up and dumped at shutdown.

Top module: `cmos_rtc_bank`

## Requirements
- R1: An index-port write stores the written bit 7 as `nmi_mask` and keeps the low 6 bits (base build) or the low 7 bits (extended build) as the register index. The new values appear one clock edge after the write.
- R2: In the extended build, when the latched bank bit is 1 and the index is 64 or above, data reads and data writes use array address index+64 (128 to 191). The bank bit is loaded from `bank_in` on `bank_ld` and resets to 0.
- R3: A data write to address 0x0A stores only bits 6:0. A data read of 0x0A returns those bits, with bit 7 equal to the update-in-progress flag.
- R4: A data write to 0x0B stores bits 6:0. A data write to 0x0D stores only bit 7 and clears bits 6:0.
- R5: After reset, 0x0A holds 0x26, 0x0B holds 0x02, 0x0D holds 0x80, the time is 00:00:00, and `nmi_mask`, the bank bit, `cpu_rdata` and `host_rdata` are 0.
- R6: A read of 0x00, 0x02 or 0x04 returns seconds, minutes or hours. The value is packed BCD (tens in bits 7:4) when bit 2 of 0x0B is 0, and binary when that bit is 1.
- R7: The seconds count advances once every `TICKS_PER_SEC` clocks, counted from reset release. Seconds wrap from 59 to 0 and carry into minutes; minutes wrap from 59 to 0 and carry into hours; hours wrap from 23 to 0.
- R8: The update-in-progress flag is 1 only in the last clock of each second, which is the clock whose edge advances the seconds count.
- R9: The alarm addresses 0x01, 0x03 and 0x05, and every address not named in R3, R4 and R6, store and return all 8 bits.
- R10: While `host_en` is 1, a `host_we` write stores `host_wdata` at `host_addr` with no mask. A read returns that byte on `host_rdata` one edge later. CPU data writes made while `host_en` is 1 are ignored.
- R11: A data write to 0x00, 0x02 or 0x04 loads that counter with the written value taken as binary. A value at or above the field's limit (60, 60 or 24) loads 0.
- R12: `cpu_rdata` takes the read value on the clock edge that samples `cpu_dat_rd` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_idx_wr | input | 1 | Index-port write strobe |
| cpu_dat_wr | input | 1 | Data-port write strobe |
| cpu_dat_rd | input | 1 | Data-port read strobe |
| cpu_wdata | input | 8 | CPU write byte (index or data) |
| cpu_rdata | output | 8 | Registered data-port read value |
| nmi_mask | output | 1 | NMI-disable flag from index bit 7 |
| bank_ld | input | 1 | Strobe that loads the bank bit |
| bank_in | input | 1 | Bank bit from the chipset register |
| host_en | input | 1 | Host access active; blocks CPU data writes |
| host_we | input | 1 | Host write strobe |
| host_addr | input | AW | Raw array address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered host read byte |

## Verification
Every result is registered, so each one is due exactly one rising edge after the strobe that causes it. This covers `nmi_mask` after an index write, `cpu_rdata` after a read strobe, `host_rdata` after a host read, and the time counters after a load. The bench drives each operation on a falling edge, computes the expected value from its own model at that moment, and samples one nanosecond after the next rising edge. The update flag and the second rollover depend on the clock count since reset. The model therefore keeps its own prescaler from reset release, and the directed rollover test starts its loads at a known prescaler phase so that the carry lands at a predictable edge.

// File: rtl/cmos_rtc_pkg.sv
package cmos_rtc_pkg;
   localparam logic [7:0] ADR_SEC  = 8'h00;
   localparam logic [7:0] ADR_MIN  = 8'h02;
   localparam logic [7:0] ADR_HR   = 8'h04;
   localparam logic [7:0] ADR_STA  = 8'h0A;
   localparam logic [7:0] ADR_STB  = 8'h0B;
   localparam logic [7:0] ADR_STD  = 8'h0D;
   localparam logic [7:0] RST_STA  = 8'h26;
   localparam logic [7:0] RST_STB  = 8'h02;
   localparam logic [7:0] RST_STD  = 8'h80;
   localparam logic [7:0] MSK_STA  = 8'h7F;
   localparam logic [7:0] MSK_STB  = 8'h7F;
   localparam logic [7:0] MSK_STD  = 8'h80;

   function automatic logic [7:0] to_bcd(input logic [7:0] v);
      logic [7:0] tens;
      tens = v / 8'd10;
      return {tens[3:0], 4'(v - tens * 8'd10)};
   endfunction
endpackage

// File: rtl/cmos_index_unit.sv
module cmos_index_unit #(
   parameter bit EXTENDED = 1'b1,
   localparam int unsigned AW = EXTENDED ? 8 : 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idx_wr,
   input  logic [7:0]    wdata,
   input  logic          bank_ld,
   input  logic          bank_in,
   output logic          nmi_mask,
   output logic          bank_q,
   output logic [AW-1:0] eff_addr
);
   localparam int unsigned IW = EXTENDED ? 7 : 6;

   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q    <= '0;
         nmi_mask <= 1'b0;
      end else if (idx_wr) begin
         idx_q    <= wdata[IW-1:0];
         nmi_mask <= wdata[7];
      end
   end

   generate
      if (EXTENDED) begin : g_ext
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       bank_q <= 1'b0;
            else if (bank_ld) bank_q <= bank_in;
         end
         always_comb begin
            if (bank_q && idx_q[6]) eff_addr = {2'b10, idx_q[5:0]};
            else                    eff_addr = {1'b0, idx_q};
         end
      end else begin : g_base
         assign bank_q   = 1'b0;
         assign eff_addr = idx_q;
      end
   endgenerate
endmodule

// File: rtl/cmos_timebase.sv
module cmos_timebase #(
   parameter int unsigned TICKS_PER_SEC = 32768,
   localparam int unsigned PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_sec,
   input  logic       ld_min,
   input  logic       ld_hr,
   input  logic [7:0] ld_val,
   output logic [5:0] sec_q,
   output logic [5:0] min_q,
   output logic [4:0] hr_q,
   output logic       uip
);
   localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

   logic [PW-1:0] pre_q;
   logic          c_sec, c_min;

   assign uip   = (pre_q == LAST);
   assign c_sec = uip && (sec_q == 6'd59);
   assign c_min = c_sec && (min_q == 6'd59);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         sec_q <= '0;
         min_q <= '0;
         hr_q  <= '0;
      end else begin
         pre_q <= uip ? '0 : pre_q + 1'b1;
         if (ld_sec)     sec_q <= (ld_val < 8'd60) ? ld_val[5:0] : 6'd0;
         else if (uip)   sec_q <= c_sec ? 6'd0 : sec_q + 6'd1;
         if (ld_min)     min_q <= (ld_val < 8'd60) ? ld_val[5:0] : 6'd0;
         else if (c_sec) min_q <= c_min ? 6'd0 : min_q + 6'd1;
         if (ld_hr)      hr_q  <= (ld_val < 8'd24) ? ld_val[4:0] : 5'd0;
         else if (c_min) hr_q  <= (hr_q == 5'd23) ? 5'd0 : hr_q + 5'd1;
      end
   end
endmodule

// File: rtl/cmos_store.sv
module cmos_store
   import cmos_rtc_pkg::*;
#(
   parameter int unsigned DEPTH = 192,
   parameter int unsigned AW    = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [AW-1:0] cpu_addr,
   input  logic [7:0]    cpu_wdata,
   output logic [7:0]    cpu_byte,
   input  logic          host_en,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   output logic [7:0]    st_a,
   output logic [7:0]    st_b,
   output logic [7:0]    st_d
);
   logic [7:0] mem [DEPTH];
   logic [7:0] wmask;

   always_comb begin
      case (8'(cpu_addr))
         ADR_STA: wmask = MSK_STA;
         ADR_STB: wmask = MSK_STB;
         ADR_STD: wmask = MSK_STD;
         default: wmask = 8'hFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (8'(i) == ADR_STA)      mem[i] <= RST_STA;
            else if (8'(i) == ADR_STB) mem[i] <= RST_STB;
            else if (8'(i) == ADR_STD) mem[i] <= RST_STD;
            else                       mem[i] <= 8'h00;
         end
         host_rdata <= 8'h00;
      end else begin
         if (host_en && host_we) begin
            if (32'(host_addr) < DEPTH) mem[host_addr] <= host_wdata;
         end else if (cpu_we && 32'(cpu_addr) < DEPTH) begin
            mem[cpu_addr] <= cpu_wdata & wmask;
         end
         if (host_en && !host_we)
            host_rdata <= (32'(host_addr) < DEPTH) ? mem[host_addr] : 8'h00;
      end
   end

   assign cpu_byte = (32'(cpu_addr) < DEPTH) ? mem[cpu_addr] : 8'h00;
   assign st_a = mem[ADR_STA];
   assign st_b = mem[ADR_STB];
   assign st_d = mem[ADR_STD];
endmodule

// File: rtl/cmos_rtc_bank.sv
module cmos_rtc_bank
   import cmos_rtc_pkg::*;
#(
   parameter bit          EXTENDED      = 1'b1,
   parameter int unsigned TICKS_PER_SEC = 32768,
   localparam int unsigned AW = EXTENDED ? 8 : 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_idx_wr,
   input  logic          cpu_dat_wr,
   input  logic          cpu_dat_rd,
   input  logic [7:0]    cpu_wdata,
   output logic [7:0]    cpu_rdata,
   output logic          nmi_mask,
   input  logic          bank_ld,
   input  logic          bank_in,
   input  logic          host_en,
   input  logic          host_we,
   input  logic [AW-1:0] host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata
);
   localparam int unsigned DEPTH = EXTENDED ? 192 : 64;

   generate
      if (TICKS_PER_SEC < 2) begin : g_bad_ticks
         $error("TICKS_PER_SEC must be at least 2");
      end
   endgenerate

   logic [AW-1:0] eff_addr;
   logic          bank_q;
   logic [5:0]    sec_q, min_q;
   logic [4:0]    hr_q;
   logic          uip;
   logic [7:0]    cpu_byte, st_a, st_b, st_d;
   logic          wr_ok, ld_sec, ld_min, ld_hr, time_ld, cpu_we;
   logic          bcd;
   logic [7:0]    rd_val;

   assign wr_ok   = cpu_dat_wr && !host_en;
   assign ld_sec  = wr_ok && (8'(eff_addr) == ADR_SEC);
   assign ld_min  = wr_ok && (8'(eff_addr) == ADR_MIN);
   assign ld_hr   = wr_ok && (8'(eff_addr) == ADR_HR);
   assign time_ld = ld_sec || ld_min || ld_hr;
   assign cpu_we  = wr_ok && !time_ld;
   assign bcd     = !st_b[2];

   cmos_index_unit #(.EXTENDED(EXTENDED)) u_idx (
      .clk(clk), .rst_n(rst_n), .idx_wr(cpu_idx_wr), .wdata(cpu_wdata),
      .bank_ld(bank_ld), .bank_in(bank_in), .nmi_mask(nmi_mask),
      .bank_q(bank_q), .eff_addr(eff_addr)
   );

   cmos_timebase #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tb (
      .clk(clk), .rst_n(rst_n), .ld_sec(ld_sec), .ld_min(ld_min),
      .ld_hr(ld_hr), .ld_val(cpu_wdata), .sec_q(sec_q), .min_q(min_q),
      .hr_q(hr_q), .uip(uip)
   );

   cmos_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
      .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(eff_addr),
      .cpu_wdata(cpu_wdata), .cpu_byte(cpu_byte), .host_en(host_en),
      .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .st_a(st_a), .st_b(st_b), .st_d(st_d)
   );

   always_comb begin
      case (8'(eff_addr))
         ADR_SEC: rd_val = bcd ? to_bcd(8'(sec_q)) : 8'(sec_q);
         ADR_MIN: rd_val = bcd ? to_bcd(8'(min_q)) : 8'(min_q);
         ADR_HR:  rd_val = bcd ? to_bcd(8'(hr_q))  : 8'(hr_q);
         ADR_STA: rd_val = {uip, cpu_byte[6:0]};
         default: rd_val = cpu_byte;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cpu_rdata <= 8'h00;
      else if (cpu_dat_rd) cpu_rdata <= rd_val;
   end
endmodule

// File: rtl/cmos_rtc_chk.sv
module cmos_rtc_chk #(
   parameter int unsigned AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cpu_idx_wr,
   input logic [7:0]    cpu_wdata,
   input logic          nmi_mask,
   input logic [AW-1:0] eff_addr,
   input logic          bank_q,
   input logic [5:0]    sec_q,
   input logic [5:0]    min_q,
   input logic [4:0]    hr_q,
   input logic          uip,
   input logic          time_ld,
   input logic          cpu_we,
   input logic          host_en,
   input logic [7:0]    st_a,
   input logic [7:0]    st_d
);
   p_nmi_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_idx_wr |=> nmi_mask == $past(cpu_wdata[7]));

   p_high_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (AW > 6 && eff_addr[AW-1]) |-> bank_q);

   p_sta_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && 8'(eff_addr) == 8'h0A) |=> !st_a[7]);

   p_std_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_we && 8'(eff_addr) == 8'h0D) |=> st_d[6:0] == 7'd0);

   p_time_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q < 6'd60 && min_q < 6'd60 && hr_q < 5'd24);

   p_uip_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (uip && !time_ld) |=> sec_q != $past(sec_q));

   p_host_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      host_en |-> !cpu_we && !time_ld);
endmodule

bind cmos_rtc_bank cmos_rtc_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_idx_wr(cpu_idx_wr), .cpu_wdata(cpu_wdata),
   .nmi_mask(nmi_mask), .eff_addr(eff_addr), .bank_q(bank_q),
   .sec_q(sec_q), .min_q(min_q), .hr_q(hr_q), .uip(uip),
   .time_ld(time_ld), .cpu_we(cpu_we), .host_en(host_en),
   .st_a(st_a), .st_d(st_d)
);

// File: tb/cmos_rtc_bank_tb.sv
`timescale 1ns/1ps
module cmos_rtc_bank_tb_top;
   localparam int T = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_idx_wr = 0, cpu_dat_wr = 0, cpu_dat_rd = 0;
   logic [7:0] cpu_wdata = 0;
   logic [7:0] cpu_rdata;
   logic nmi_mask;
   logic bank_ld = 0, bank_in = 0;
   logic host_en = 0, host_we = 0;
   logic [7:0] host_addr = 0, host_wdata = 0;
   logic [7:0] host_rdata;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   cmos_rtc_bank #(.EXTENDED(1'b1), .TICKS_PER_SEC(T)) dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_idx_wr(cpu_idx_wr), .cpu_dat_wr(cpu_dat_wr),
      .cpu_dat_rd(cpu_dat_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .nmi_mask(nmi_mask), .bank_ld(bank_ld), .bank_in(bank_in),
      .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   // reference model built from the requirements
   logic [7:0] m_arr [192];
   logic [6:0] m_idx;
   logic       m_nmi, m_bank;
   int         m_pre, m_sec, m_min, m_hr;

   function automatic logic [7:0] m_eff();
      return (m_bank && m_idx[6]) ? {2'b10, m_idx[5:0]} : {1'b0, m_idx};
   endfunction

   function automatic logic [7:0] bcdf(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   function automatic logic [7:0] exp_read();
      logic [7:0] a;
      bit b;
      a = m_eff();
      b = !m_arr[11][2];
      case (a)
         8'h00: return b ? bcdf(m_sec) : 8'(m_sec);
         8'h02: return b ? bcdf(m_min) : 8'(m_min);
         8'h04: return b ? bcdf(m_hr)  : 8'(m_hr);
         8'h0A: return {m_pre == T - 1, m_arr[10][6:0]};
         default: return m_arr[a];
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      if (a == 8'h00 || a == 8'h02 || a == 8'h04) return "R6";
      if (a == 8'h0A) return "R3";
      if (a == 8'h0B || a == 8'h0D) return "R4";
      if (a >= 8'd128) return "R2";
      return "R9";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 192; i++) m_arr[i] <= 8'h00;
         m_arr[10] <= 8'h26; m_arr[11] <= 8'h02; m_arr[13] <= 8'h80;
         m_idx <= 0; m_nmi <= 0; m_bank <= 0;
         m_pre <= 0; m_sec <= 0; m_min <= 0; m_hr <= 0;
      end else begin
         int s, mi, h;
         logic [7:0] a;
         bit tick;
         tick = (m_pre == T - 1);
         m_pre <= tick ? 0 : m_pre + 1;
         s = m_sec; mi = m_min; h = m_hr;
         if (tick) begin
            s = s + 1;
            if (s == 60) begin
               s = 0; mi = mi + 1;
               if (mi == 60) begin
                  mi = 0; h = (h + 1) % 24;
               end
            end
         end
         a = m_eff();
         if (cpu_dat_wr && !host_en) begin
            case (a)
               8'h00: s  = (cpu_wdata < 60) ? int'(cpu_wdata) : 0;
               8'h02: mi = (cpu_wdata < 60) ? int'(cpu_wdata) : 0;
               8'h04: h  = (cpu_wdata < 24) ? int'(cpu_wdata) : 0;
               8'h0A: m_arr[a] <= cpu_wdata & 8'h7F;
               8'h0B: m_arr[a] <= cpu_wdata & 8'h7F;
               8'h0D: m_arr[a] <= cpu_wdata & 8'h80;
               default: m_arr[a] <= cpu_wdata;
            endcase
         end
         if (host_en && host_we) m_arr[host_addr] <= host_wdata;
         m_sec <= s; m_min <= mi; m_hr <= h;
         if (cpu_idx_wr) begin
            m_idx <= cpu_wdata[6:0];
            m_nmi <= cpu_wdata[7];
         end
         if (bank_ld) m_bank <= bank_in;
      end
   end

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic idx_wr(input logic [7:0] v, input bit check);
      @(negedge clk);
      cpu_wdata = v; cpu_idx_wr = 1;
      @(posedge clk); #1;
      cpu_idx_wr = 0;
      if (check) chk("R1 nmi", {7'd0, nmi_mask}, {7'd0, v[7]});
   endtask

   task automatic dat_wr(input logic [7:0] v);
      @(negedge clk);
      cpu_wdata = v; cpu_dat_wr = 1;
      @(posedge clk); #1;
      cpu_dat_wr = 0;
   endtask

   task automatic dat_rd(input string req);
      logic [7:0] e;
      string t;
      @(negedge clk);
      e = exp_read();
      t = (req == "") ? tag_of(m_eff()) : req;
      cpu_dat_rd = 1;
      @(posedge clk); #1;
      cpu_dat_rd = 0;
      chk(t, cpu_rdata, e);
   endtask

   task automatic bank_set(input bit b);
      @(negedge clk);
      bank_in = b; bank_ld = 1;
      @(posedge clk); #1;
      bank_ld = 0;
   endtask

   task automatic host_op(input bit we, input logic [7:0] a, input logic [7:0] d);
      logic [7:0] e;
      @(negedge clk);
      e = m_arr[a];
      host_en = 1; host_we = we; host_addr = a; host_wdata = d;
      @(posedge clk); #1;
      host_en = 0; host_we = 0;
      if (!we) chk("R10 host read", host_rdata, e);
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      #1;
      // R5 reset state
      chk("R5 nmi", {7'd0, nmi_mask}, 8'h00);
      chk("R5 rdata", cpu_rdata, 8'h00);
      chk("R5 host_rdata", host_rdata, 8'h00);
      idx_wr(8'h0A, 1'b1); dat_rd("R5 regA");
      chk("R5 regA stored", m_arr[10], 8'h26);
      idx_wr(8'h0B, 1'b1); dat_rd("R5 regB");
      idx_wr(8'h0D, 1'b1); dat_rd("R5 regD");
      host_op(1'b0, 8'h0D, 8'h00);

      // R3/R4 masks
      idx_wr(8'h8A, 1'b1); dat_wr(8'hFF); dat_rd("R3");
      idx_wr(8'h0D, 1'b1); dat_wr(8'h7F); dat_rd("R4 regD low");
      dat_wr(8'hFF); dat_rd("R4 regD high");
      idx_wr(8'h0B, 1'b0); dat_wr(8'hFF); dat_rd("R4 regB");
      dat_wr(8'h02);

      // R9 alarms and plain storage
      idx_wr(8'h01, 1'b0); dat_wr(8'hA5); dat_rd("R9 alarm");
      idx_wr(8'h05, 1'b0); dat_wr(8'hFE); dat_rd("R9 alarm");
      idx_wr(8'h3F, 1'b0); dat_wr(8'h81); dat_rd("R9 top");

      // R2 bank remap: write 0x50 with bank off and on, read both
      idx_wr(8'h50, 1'b0); dat_wr(8'h11);
      bank_set(1'b1); dat_wr(8'h22); dat_rd("R2 bank on");
      host_op(1'b0, 8'h90, 8'h00);
      host_op(1'b0, 8'h50, 8'h00);
      bank_set(1'b0); dat_rd("R2 bank off");
      idx_wr(8'h30, 1'b0); bank_set(1'b1); dat_rd("R2 low index unaffected");
      bank_set(1'b0);

      // R10 host preload and blocked CPU write
      host_op(1'b1, 8'h20, 8'h5A); host_op(1'b0, 8'h20, 8'h00);
      idx_wr(8'h20, 1'b0); dat_rd("R10 preload visible");
      host_op(1'b1, 8'h0A, 8'hFF); host_op(1'b0, 8'h0A, 8'h00);
      @(negedge clk);
      host_en = 1; cpu_wdata = 8'h00; cpu_dat_wr = 1;
      @(posedge clk); #1;
      host_en = 0; cpu_dat_wr = 0;
      dat_rd("R10 cpu write blocked");
      host_op(1'b0, 8'h20, 8'h00);

      // R11 out-of-range loads
      idx_wr(8'h00, 1'b0); dat_wr(8'd75); dat_rd("R11 sec");
      idx_wr(8'h04, 1'b0); dat_wr(8'd30); dat_rd("R11 hr");

      // R7 full rollover 23:59:59 -> 00:00:00, loads start at phase 2
      while (m_pre != 1) @(negedge clk);
      idx_wr(8'h04, 1'b0); dat_wr(8'd23);
      idx_wr(8'h02, 1'b0); dat_wr(8'd59);
      idx_wr(8'h00, 1'b0); dat_wr(8'd59);
      cycles(T);
      dat_rd("R7 sec wrap");
      chk("R7 model sec", 8'(m_sec), 8'h00);
      idx_wr(8'h02, 1'b0); dat_rd("R7 min wrap");
      idx_wr(8'h04, 1'b0); dat_rd("R7 hr wrap");

      // R6 binary mode then back to BCD
      idx_wr(8'h02, 1'b0); dat_wr(8'd47);
      idx_wr(8'h0B, 1'b0); dat_wr(8'h06);
      idx_wr(8'h02, 1'b0); dat_rd("R6 binary");
      idx_wr(8'h0B, 1'b0); dat_wr(8'h02);
      idx_wr(8'h02, 1'b0); dat_rd("R6 bcd");

      // R8 update flag over two seconds; R12 hold without strobe
      idx_wr(8'h0A, 1'b0);
      for (int i = 0; i < 2 * T; i++) dat_rd("R8");
      begin
         logic [7:0] held;
         held = cpu_rdata;
         cycles(5);
         chk("R12 hold", cpu_rdata, held);
      end

      // constrained random mix
      for (int n = 0; n < 800; n++) begin
         int k;
         logic [7:0] ix;
         k = $urandom % 10;
         case ($urandom % 4)
            0: ix = 8'($urandom % 16);
            1: ix = 8'(64 + $urandom % 64);
            2: ix = 8'($urandom % 128);
            default: ix = 8'($urandom % 14);
         endcase
         ix[7] = 1'($urandom);
         case (k)
            0, 1: idx_wr(ix, 1'b1);
            2, 3: dat_wr(8'($urandom));
            4, 5, 6: dat_rd("");
            7: bank_set(1'($urandom));
            8: host_op(1'b0, 8'($urandom % 192), 8'h00);
            default: host_op(1'b1, 8'(16 + $urandom % 176), 8'($urandom));
         endcase
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule